// File: doc/BRIEF.md
# Fine-Grain Multithreaded Issue Controller

This block is the issue stage of a SIMD control unit that runs several hardware threads at once. Each thread keeps its own program counter and a ready state. On every clock edge the stage picks one ready thread in round-robin order. It forwards that thread's current instruction word and steers it toward the path its class needs. Scalar work stays in the control unit. Broadcast/parallel work goes out on the broadcast network into the PE array. Reduction work uses the broadcast network and also the reduction network that combines PE results. The class comes from the top two bits of the instruction word.

Instructions from different threads are independent, so the stage never stalls one thread because of another thread's data. A thread that issues a reduction is parked. It stays parked for a fixed number of cycles that covers the network latency, or until a completion pulse for it arrives, whichever comes first. While a thread is parked, the other threads fill its issue slots. Only when no thread can issue does the stage put out a bubble, and a saturating counter records each bubble.

The instruction memory and the datapaths sit outside the block. Each thread's program counter is an output. The instruction word addressed by that program counter comes back on the per-thread instruction input in the same cycle.

Top module: `mt_issue_ctrl`

## Requirements
- R1: While reset is held, issue_vld_o is 0, issue_route_o is 0, every thread program counter is 0 and bubble_cnt_o is 0. After reset, thread 0 is the first thread the round-robin search tries.
- R2: On each edge, the stage searches the threads starting with the one after the last issued thread (index + 1, wrapping). It issues the first ready thread it finds. A thread therefore issues in two consecutive cycles only when it is the only ready thread.
- R3: A thread whose thr_active_i bit is 0 is never issued, and its program counter does not change.
- R4: The instruction class is bits [IW-1:IW-2] of the word. The route output has bit 0 for the control unit, bit 1 for the broadcast network and bit 2 for the reduction network. Class 00 (scalar) gives route 001. Class 01 (broadcast/parallel) gives 010. Class 10 (reduction) gives 110.
- R5: Class 11 is a no-op. It still issues with issue_vld_o = 1, with route 000, and its thread's program counter advances.
- R6: On an issue, the issued thread's program counter increases by one, wrapping at 2^PCW. All other program counters keep their values.
- R7: A thread that issues a reduction at edge k is not ready at edges k+1 through k+RED_LAT. It is ready again at edge k+RED_LAT+1, unless a completion pulse arrives first.
- R8: If red_done_i[t] is 1 at an edge, a parked thread t becomes ready from the next edge onward. A pulse for a thread that is not parked has no effect. A reduction issued at the same edge as a pulse parks the thread for the full RED_LAT.
- R9: When no thread is ready, issue_vld_o is 0 and issue_route_o is 000, and bubble_cnt_o increases by one. The counter saturates at 2^CNTW-1 and does not change on an issue cycle.
- R10: On an issue, issue_tid_o carries the thread index and issue_instr_o carries that thread's instruction word exactly as sampled at the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| thr_active_i | input | NTHR | Thread t has an instruction to run |
| instr_i | input | NTHR*IW | Instruction word at each thread's program counter, thread t at [t*IW +: IW] |
| red_done_i | input | NTHR | Reduction completion pulse, one bit per thread |
| issue_vld_o | output | 1 | An instruction issued this cycle |
| issue_tid_o | output | $clog2(NTHR) | Thread index of the issued instruction |
| issue_route_o | output | 3 | Path enables: bit 0 control unit, bit 1 broadcast network, bit 2 reduction network |
| issue_instr_o | output | IW | Issued instruction word |
| thr_pc_o | output | NTHR*PCW | Per-thread program counters, thread t at [t*PCW +: PCW] |
| bubble_cnt_o | output | CNTW | Saturating count of bubble cycles |

## Verification
The bench builds the block with four threads, 16-bit words, 8-bit program counters, a reduction latency of 3 and a 4-bit bubble counter. With only two threads running reductions back to back, the latency of 3 leaves guaranteed gaps, so bubbles appear and the narrow counter reaches its saturation value early in the run. A wrapping 8-bit program counter and generated instruction words let a behavioural model follow every thread. That model covers rotation with some threads disabled, a single thread issuing alone, early completion pulses against the full parking window, and the no-op class.

// File: rtl/mti_pkg.sv
package mti_pkg;

    typedef enum logic [1:0] {
        OP_SCALAR = 2'b00,
        OP_BCAST  = 2'b01,
        OP_REDUCE = 2'b10,
        OP_NOP    = 2'b11
    } op_kind_e;

    typedef struct packed {
        logic red_net;
        logic bc_net;
        logic cu;
    } route_t;

    function automatic op_kind_e kind_of(input logic [1:0] top_bits);
        return op_kind_e'(top_bits);
    endfunction

    function automatic route_t route_of(input op_kind_e kind);
        route_t r;
        r = '0;
        case (kind)
            OP_SCALAR: r.cu = 1'b1;
            OP_BCAST:  r.bc_net = 1'b1;
            OP_REDUCE: begin
                r.bc_net  = 1'b1;
                r.red_net = 1'b1;
            end
            default:   r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/mti_rr_pick.sv
module mti_rr_pick #(
    parameter int N  = 4,
    parameter int TW = 2
) (
    input  logic [N-1:0]  req,
    input  logic [TW-1:0] last,
    output logic          found,
    output logic [TW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int k = 1; k <= N; k++) begin
            int c;
            c = (int'(last) + k) % N;
            if (!found && req[c]) begin
                found = 1'b1;
                idx   = TW'(c);
            end
        end
    end
endmodule

// File: rtl/mti_thread_slot.sv
module mti_thread_slot #(
    parameter int PCW = 8,
    parameter int LAT = 4,
    parameter int WW  = 3
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           active,
    input  logic           take,
    input  logic           take_red,
    input  logic           done,
    output logic [PCW-1:0] pc,
    output logic           ready
);
    logic [WW-1:0] wait_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc     <= '0;
            wait_q <= '0;
        end else begin
            if (take)
                pc <= pc + 1'b1;
            if (take && take_red)
                wait_q <= WW'(LAT);
            else if (done)
                wait_q <= '0;
            else if (wait_q != '0)
                wait_q <= wait_q - 1'b1;
        end
    end

    assign ready = active && (wait_q == '0);
endmodule

// File: rtl/mti_sat_ctr.sv
module mti_sat_ctr #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (inc && (cnt != '1))
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/mt_issue_ctrl.sv
module mt_issue_ctrl
    import mti_pkg::*;
#(
    parameter int NTHR    = 4,
    parameter int IW      = 32,
    parameter int PCW     = 16,
    parameter int RED_LAT = 4,
    parameter int CNTW    = 16,
    localparam int TW     = (NTHR > 1) ? $clog2(NTHR) : 1,
    localparam int WW     = $clog2(RED_LAT + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NTHR-1:0]     thr_active_i,
    input  logic [NTHR*IW-1:0]  instr_i,
    input  logic [NTHR-1:0]     red_done_i,
    output logic                issue_vld_o,
    output logic [TW-1:0]       issue_tid_o,
    output logic [2:0]          issue_route_o,
    output logic [IW-1:0]       issue_instr_o,
    output logic [NTHR*PCW-1:0] thr_pc_o,
    output logic [CNTW-1:0]     bubble_cnt_o
);
    logic [NTHR-1:0] ready;
    logic [NTHR-1:0] take;
    logic [TW-1:0]   last_q;
    logic            pick_found;
    logic [TW-1:0]   pick_idx;
    logic [IW-1:0]   sel_instr;
    op_kind_e        sel_kind;
    route_t          sel_route;

    mti_rr_pick #(.N(NTHR), .TW(TW)) u_pick (
        .req   (ready),
        .last  (last_q),
        .found (pick_found),
        .idx   (pick_idx)
    );

    always_comb begin
        sel_instr = instr_i[int'(pick_idx)*IW +: IW];
        sel_kind  = kind_of(sel_instr[IW-1 -: 2]);
        sel_route = route_of(sel_kind);
    end

    for (genvar t = 0; t < NTHR; t++) begin : g_thr
        assign take[t] = pick_found && (pick_idx == TW'(t));

        mti_thread_slot #(.PCW(PCW), .LAT(RED_LAT), .WW(WW)) u_slot (
            .clk      (clk),
            .rst      (rst),
            .active   (thr_active_i[t]),
            .take     (take[t]),
            .take_red (sel_kind == OP_REDUCE),
            .done     (red_done_i[t]),
            .pc       (thr_pc_o[t*PCW +: PCW]),
            .ready    (ready[t])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            issue_vld_o   <= 1'b0;
            issue_tid_o   <= '0;
            issue_route_o <= '0;
            issue_instr_o <= '0;
            last_q        <= TW'(NTHR - 1);
        end else begin
            issue_vld_o <= pick_found;
            if (pick_found) begin
                issue_tid_o   <= pick_idx;
                issue_route_o <= sel_route;
                issue_instr_o <= sel_instr;
                last_q        <= pick_idx;
            end else begin
                issue_route_o <= '0;
            end
        end
    end

    mti_sat_ctr #(.W(CNTW)) u_bubble (
        .clk (clk),
        .rst (rst),
        .inc (!pick_found),
        .cnt (bubble_cnt_o)
    );
endmodule

// File: rtl/mt_issue_ctrl_chk.sv
module mt_issue_ctrl_chk #(
    parameter int NTHR = 4,
    parameter int PCW  = 16,
    parameter int CNTW = 16,
    parameter int TW   = 2
) (
    input logic                clk,
    input logic                rst,
    input logic                issue_vld_o,
    input logic [TW-1:0]       issue_tid_o,
    input logic [2:0]          issue_route_o,
    input logic [NTHR*PCW-1:0] thr_pc_o,
    input logic [CNTW-1:0]     bubble_cnt_o
);
    logic                live;
    logic [NTHR*PCW-1:0] pc_prev;
    logic [CNTW-1:0]     cnt_prev;
    logic                red_prev;
    logic [TW-1:0]       tid_prev;
    logic [PCW-1:0]      pc_now;
    logic [PCW-1:0]      pc_exp;

    always_ff @(posedge clk) begin
        live     <= !rst;
        pc_prev  <= thr_pc_o;
        cnt_prev <= bubble_cnt_o;
        red_prev <= issue_vld_o && issue_route_o[2];
        tid_prev <= issue_tid_o;
    end

    always_comb begin
        pc_now = thr_pc_o[int'(issue_tid_o)*PCW +: PCW];
        pc_exp = pc_prev[int'(issue_tid_o)*PCW +: PCW] + 1'b1;
    end

    assert_idle_route_R9: assert property (@(posedge clk) disable iff (rst)
        !issue_vld_o |-> (issue_route_o == 3'b000));

    assert_red_uses_bcast_R4: assert property (@(posedge clk) disable iff (rst)
        (issue_vld_o && issue_route_o[2]) |-> (issue_route_o[1] && !issue_route_o[0]));

    assert_bubble_step_R9: assert property (@(posedge clk) disable iff (rst)
        (live && !issue_vld_o && (cnt_prev != '1)) |-> (bubble_cnt_o == cnt_prev + 1'b1));

    assert_bubble_sat_R9: assert property (@(posedge clk) disable iff (rst)
        (live && (cnt_prev == '1)) |-> (bubble_cnt_o == '1));

    assert_bubble_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (live && issue_vld_o) |-> (bubble_cnt_o == cnt_prev));

    assert_pc_step_R6: assert property (@(posedge clk) disable iff (rst)
        (live && issue_vld_o) |-> (pc_now == pc_exp));

    assert_red_park_R7: assert property (@(posedge clk) disable iff (rst)
        (live && red_prev) |-> !(issue_vld_o && (issue_tid_o == tid_prev)));
endmodule

bind mt_issue_ctrl mt_issue_ctrl_chk #(
    .NTHR (NTHR),
    .PCW  (PCW),
    .CNTW (CNTW),
    .TW   (TW)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .issue_vld_o   (issue_vld_o),
    .issue_tid_o   (issue_tid_o),
    .issue_route_o (issue_route_o),
    .thr_pc_o      (thr_pc_o),
    .bubble_cnt_o  (bubble_cnt_o)
);

// File: tb/sim_mt_issue_ctrl.sv
`timescale 1ns/1ps
module sim_mt_issue_ctrl;
    localparam int N    = 4;
    localparam int IW   = 16;
    localparam int PCW  = 8;
    localparam int LAT  = 3;
    localparam int CNTW = 4;
    localparam int CMAX = 15;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [N-1:0]      act = '0;
    logic [N*IW-1:0]   instr = '0;
    logic [N-1:0]      done = '0;
    logic              vld;
    logic [1:0]        tid;
    logic [2:0]        route;
    logic [IW-1:0]     iword;
    logic [N*PCW-1:0]  pcs;
    logic [CNTW-1:0]   bub;

    int checks = 0;
    int fails  = 0;

    int mpc [N];
    int mw  [N];
    int mlast;
    int mbub;
    int mode;
    int lf = 32'h1234_5677;

    always #2 clk = ~clk;

    mt_issue_ctrl #(.NTHR(N), .IW(IW), .PCW(PCW), .RED_LAT(LAT), .CNTW(CNTW)) u0 (
        .clk(clk), .rst(rst), .thr_active_i(act), .instr_i(instr),
        .red_done_i(done), .issue_vld_o(vld), .issue_tid_o(tid),
        .issue_route_o(route), .issue_instr_o(iword), .thr_pc_o(pcs),
        .bubble_cnt_o(bub)
    );

    function automatic int op_of(int t, int pc, int md);
        case (md)
            0:       return 0;
            1:       return (t + pc) % 4;
            2:       return 2;
            default: return (t * 7 + pc * 3 + pc / 3) % 4;
        endcase
    endfunction

    function automatic logic [IW-1:0] word_of(int t, int pc, int md);
        return {2'(op_of(t, pc, md)), 6'(t), 8'(pc)};
    endfunction

    function automatic int route_for(int op);
        case (op)
            0:       return 1;
            1:       return 2;
            2:       return 6;
            default: return 0;
        endcase
    endfunction

    function automatic int rnd();
        lf = lf * 1103515245 + 12345;
        return (lf >>> 8) & 32'hFFFF;
    endfunction

    task automatic chk(string req, string what, int actual, int expected);
        checks++;
        if (actual != expected) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, actual, expected);
        end
    endtask

    task automatic step(logic [N-1:0] a, logic [N-1:0] d, string tag);
        int sel, op, evld, etid, eroute, einstr;
        act  = a;
        done = d;
        for (int t = 0; t < N; t++)
            instr[t*IW +: IW] = word_of(t, mpc[t], mode);
        sel = -1;
        for (int k = 1; k <= N; k++) begin
            int c;
            c = (mlast + k) % N;
            if (sel < 0 && a[c] && mw[c] == 0) sel = c;
        end
        op = 0; evld = 0; etid = 0; eroute = 0; einstr = 0;
        if (sel >= 0) begin
            op     = op_of(sel, mpc[sel], mode);
            evld   = 1;
            etid   = sel;
            eroute = route_for(op);
            einstr = int'(word_of(sel, mpc[sel], mode));
        end
        for (int t = 0; t < N; t++) begin
            if (t == sel && op == 2) mw[t] = LAT;
            else if (d[t])           mw[t] = 0;
            else if (mw[t] > 0)      mw[t] = mw[t] - 1;
        end
        if (sel >= 0) begin
            mpc[sel] = (mpc[sel] + 1) % 256;
            mlast    = sel;
        end else if (mbub < CMAX) begin
            mbub++;
        end
        @(posedge clk);
        #1;
        chk("R9", "issue_vld", int'(vld), evld);
        if (evld == 1) begin
            chk(tag, "issue_tid (R2)", int'(tid), etid);
            chk(op == 3 ? "R5" : "R4", "route", int'(route), eroute);
            chk("R10", "issue_instr", int'(iword), einstr);
        end else begin
            chk("R9", "idle route", int'(route), 0);
        end
        for (int t = 0; t < N; t++)
            chk("R6", "thread pc", int'(pcs[t*PCW +: PCW]), mpc[t]);
        chk("R9", "bubble count", int'(bub), mbub);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual expired expected finished");
        $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
        $finish;
    end

    initial begin
        for (int t = 0; t < N; t++) begin
            mpc[t] = 0;
            mw[t]  = 0;
        end
        mlast = N - 1;
        mbub  = 0;
        mode  = 0;
        act   = '1;
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "reset vld", int'(vld), 0);
        chk("R1", "reset route", int'(route), 0);
        chk("R1", "reset pcs", int'(pcs), 0);
        chk("R1", "reset bubble", int'(bub), 0);
        rst = 1'b0;

        // R1: first issue after reset goes to thread 0
        mode = 0;
        step(4'b1111, 4'b0000, "R1");
        for (int i = 0; i < 11; i++) step(4'b1111, 4'b0000, "R2");

        // R3: thread 2 disabled, mixed classes incl. no-op
        mode = 1;
        for (int i = 0; i < 16; i++) step(4'b1011, 4'b0000, "R3");

        // R2: a lone ready thread issues back to back
        for (int i = 0; i < 6; i++) step(4'b0001, 4'b0000, "R2");

        // R7: two threads issuing only reductions leave gaps
        mode = 2;
        for (int i = 0; i < 20; i++) step(4'b0011, 4'b0000, "R7");

        // R9: nothing ready, counter reaches saturation
        for (int i = 0; i < 12; i++) step(4'b0000, 4'b0000, "R9");

        // R8: completion pulses, some hitting threads that are not parked
        for (int i = 0; i < 40; i++) step(4'b1111, 4'(rnd()), "R8");

        // R4: random activity, random pulses, hashed classes
        mode = 3;
        for (int i = 0; i < 200; i++) step(4'(rnd() | rnd()), 4'(rnd() & rnd()), "R4");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule